// File: doc/BRIEF.md
# Wraparound Burst Address Sequencer

This block produces the address for a short burst on a synchronous memory port. When an address strobe is accepted, it captures the whole presented address. The low bits become the base of the burst, and the burst index returns to zero. On each later clock edge where the advance input is low, it moves to the next address in the burst. After the last step it wraps back to the base. The upper address bits stay fixed at the captured value for the whole burst.

Two strobes can start a burst. The controller strobe is always honoured. The processor strobe is honoured only while the chip-enable input is low. If both are active, the processor strobe is the one that counts. A static order-select input picks the stepping rule. In linear order the index is added to the base, modulo the burst length. In interleaved order the index is XORed into the base. A library parameter can instead fix the order at build time.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` and `burst_idx` are both zero.
- R2: At a clock edge where `ctrl_stb_n` is low, the whole `addr_in` is captured. From the next cycle `addr_out` equals it and `burst_idx` is 0. This holds whatever the value of `chip_en_n`.
- R3: At a clock edge where `proc_stb_n` and `chip_en_n` are both low, the whole `addr_in` is captured in the same way as in R2.
- R4: A low `proc_stb_n` while `chip_en_n` is high, with `ctrl_stb_n` high, captures nothing. The block behaves exactly as it does with no strobe, so `adv_n` still holds or steps it.
- R5: When both strobes are low and `chip_en_n` is low, exactly one capture takes place, and it is credited to the processor strobe.
- R6: With `order_sel` = 0 (linear), the low two bits of `addr_out` equal (base + `burst_idx`) mod 4.
- R7: With `order_sel` = 1 (interleaved), the low two bits of `addr_out` equal base XOR `burst_idx`. `order_sel` acts without a clock edge.
- R8: At an edge with no accepted strobe and `adv_n` low, `burst_idx` goes up by one. After index 3 it wraps to 0, which brings `addr_out` back to the starting address.
- R9: At an edge with no accepted strobe and `adv_n` high, `burst_idx` and `addr_out` hold.
- R10: `adv_n` has no effect at an edge where a strobe is accepted. `burst_idx` is 0 afterwards.
- R11: The upper address bits of `addr_out` change only at a capture. Values on `addr_in` between captures have no effect.
- R12: A strobe accepted in the middle of a burst restarts the burst from the new base, with `burst_idx` set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by `chip_en_n` |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, always honoured |
| chip_en_n | input | 1 | Chip enable, active low; qualifies `proc_stb_n` only |
| adv_n | input | 1 | Advance, active low |
| order_sel | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Address presented with a strobe |
| addr_out | output | ADDR_W | Current burst address |
| burst_idx | output | BURST_W | Step number within the burst |

## Verification
Two bursts are walked through all four steps and across the wrap. One runs in linear order from base 01, and the other in interleaved order from base 10. Because the bases differ, the addition rule and the XOR rule give different addresses at several steps. Separate rows do each of the following:
- They pair the gated processor strobe with advance high and then with advance low. This distinguishes "ignored" from "loaded", and from "loaded but stuck".
- They drive junk on the address input between strobes, to show the upper bits are held.
- They restart a burst in its middle with both strobes active.
- They flip the order select without a clock edge, to show it takes effect at once.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic [1:0] {
      ORD_PIN    = 2'd0,
      ORD_LINEAR = 2'd1,
      ORD_XOR    = 2'd2
   } order_cfg_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PROC = 2'd1,
      SRC_CTRL = 2'd2
   } strobe_src_e;

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
   import burst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic proc_stb_n,
   input  logic ctrl_stb_n,
   input  logic chip_en_n,
   output logic load
);

   strobe_src_e src;

   always_comb begin
      if (!proc_stb_n && !chip_en_n)
         src = SRC_PROC;
      else if (!ctrl_stb_n)
         src = SRC_CTRL;
      else
         src = SRC_NONE;
   end

   assign load = (src != SRC_NONE);

   assert_gated_proc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en_n && ctrl_stb_n) |-> !load);

   assert_proc_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && !ctrl_stb_n && !chip_en_n) |-> (load && src == SRC_PROC));

   assert_ctrl_ungated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_stb_n |-> load);

endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               adv_n,
   output logic [BURST_W-1:0] step
);

   localparam logic [BURST_W-1:0] ONE = {{(BURST_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step <= '0;
      else if (load)
         step <= '0;
      else if (!adv_n)
         step <= step + ONE;
   end

   assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (step == '0));

   assert_advance_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n) |=> (step == $past(step) + ONE));

   assert_suspend_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=> $stable(step));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int         BURST_W   = 2,
   parameter order_cfg_e ORDER_CFG = ORD_PIN
) (
   input  logic [BURST_W-1:0] base,
   input  logic [BURST_W-1:0] step,
   input  logic               order_sel,
   output logic [BURST_W-1:0] low
);

   logic [BURST_W-1:0] lin_low;
   logic [BURST_W-1:0] xor_low;

   assign lin_low = base + step;

   for (genvar b = 0; b < BURST_W; b++) begin : g_xor_bit
      assign xor_low[b] = base[b] ^ step[b];
   end

   if (ORDER_CFG == ORD_LINEAR) begin : g_lin_only
      assign low = lin_low;
   end else if (ORDER_CFG == ORD_XOR) begin : g_xor_only
      assign low = xor_low;
   end else begin : g_pin_sel
      assign low = order_sel ? xor_low : lin_low;
   end

   always_comb begin
      if (step == '0)
         assert_first_is_base_R6: assert (low == base);
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int         ADDR_W    = 15,
   parameter int         BURST_W   = 2,
   parameter order_cfg_e ORDER_CFG = ORD_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              chip_en_n,
   input  logic              adv_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BURST_W-1:0] burst_idx
);

   localparam int HI_W = ADDR_W - BURST_W;

   if (BURST_W < 1) begin : g_bad_burst
      $error("burst_addr_gen: BURST_W must be at least 1");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed BURST_W");
   end

   logic               load;
   logic [HI_W-1:0]    hi_q;
   logic [BURST_W-1:0] base_q;
   logic [BURST_W-1:0] step;
   logic [BURST_W-1:0] low;

   burst_strobe_arb u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .chip_en_n  (chip_en_n),
      .load       (load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         base_q <= '0;
      end else if (load) begin
         hi_q   <= addr_in[ADDR_W-1:BURST_W];
         base_q <= addr_in[BURST_W-1:0];
      end
   end

   burst_step_ctr #(.BURST_W(BURST_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .adv_n (adv_n),
      .step  (step)
   );

   burst_order_map #(.BURST_W(BURST_W), .ORDER_CFG(ORDER_CFG)) u_map (
      .base      (base_q),
      .step      (step),
      .order_sel (order_sel),
      .low       (low)
   );

   assign addr_out  = {hi_q, low};
   assign burst_idx = step;

   assert_capture_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_out == $past(addr_in) && burst_idx == '0));

   assert_upper_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_out[ADDR_W-1:BURST_W]));

   assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (load && burst_idx != '0) |=> (burst_idx == '0));

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

   localparam int AW = 15;
   localparam int BW = 2;
   localparam int NV = 16;

   typedef struct packed {
      logic          c;
      logic          p;
      logic          e;
      logic          a;
      logic          m;
      logic [AW-1:0] ai;
      logic [AW-1:0] ea;
      logic [BW-1:0] ei;
   } vec_t;

   // fields: ctrl_n, proc_n, ce_n, adv_n, order, addr_in, exp addr, exp idx
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b1,1'b1,1'b0,15'h1235,15'h1235,2'd0}, // R2 ctrl load, ce high
      '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h5555,15'h1236,2'd1}, // R6 R11
      '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h2AAA,15'h1237,2'd2}, // R6
      '{1'b1,1'b1,1'b1,1'b1,1'b0,15'h5555,15'h1237,2'd2}, // R9
      '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h5555,15'h1234,2'd3}, // R6
      '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h5555,15'h1235,2'd0}, // R8 wrap
      '{1'b1,1'b0,1'b0,1'b0,1'b1,15'h0A6E,15'h0A6E,2'd0}, // R3 R10
      '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h7FFF,15'h0A6F,2'd1}, // R7
      '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h7FFF,15'h0A6C,2'd2}, // R7
      '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h7FFF,15'h0A6D,2'd3}, // R7
      '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h7FFF,15'h0A6E,2'd0}, // R8 wrap
      '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h0000,15'h0A6F,2'd1}, // R7
      '{1'b1,1'b0,1'b1,1'b1,1'b1,15'h7FFF,15'h0A6F,2'd1}, // R4 gated, hold
      '{1'b1,1'b0,1'b1,1'b0,1'b1,15'h7FFF,15'h0A6C,2'd2}, // R4 gated, step
      '{1'b0,1'b0,1'b0,1'b0,1'b0,15'h3FF3,15'h3FF3,2'd0}, // R5 R12 R10
      '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h1111,15'h3FF0,2'd1}  // R6 R11
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          proc_stb_n = 1'b1;
   logic          ctrl_stb_n = 1'b1;
   logic          chip_en_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [BW-1:0] burst_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BURST_W(BW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .chip_en_n  (chip_en_n),
      .adv_n      (adv_n),
      .order_sel  (order_sel),
      .addr_in    (addr_in),
      .addr_out   (addr_out),
      .burst_idx  (burst_idx)
   );

   task automatic check(input string req, input logic [AW-1:0] ea, input logic [BW-1:0] ei);
      n_chk++;
      if (addr_out !== ea || burst_idx !== ei) begin
         n_bad++;
         $display("FAIL %s: addr=%h idx=%0d expected addr=%h idx=%0d",
                  req, addr_out, burst_idx, ea, ei);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1: watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", '0, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         ctrl_stb_n = VEC[i].c;
         proc_stb_n = VEC[i].p;
         chip_en_n  = VEC[i].e;
         adv_n      = VEC[i].a;
         order_sel  = VEC[i].m;
         addr_in    = VEC[i].ai;
         @(negedge clk);
         check($sformatf("table row %0d", i), VEC[i].ea, VEC[i].ei);
      end

      // R7: order select acts combinationally (base 11, idx 1 -> 11^01 = 10)
      adv_n = 1'b1;
      #2 order_sel = 1'b1;
      #1 check("R7 live order switch", 15'h3FF2, 2'd1);
      order_sel = 1'b0;
      #1 check("R6 live order switch back", 15'h3FF0, 2'd1);

      // R12: restart from a fresh base by the ctrl strobe mid-burst
      @(negedge clk);
      ctrl_stb_n = 1'b0; addr_in = 15'h0102; adv_n = 1'b0;
      @(negedge clk);
      check("R12 ctrl restart", 15'h0102, 2'd0);
      ctrl_stb_n = 1'b1;
      @(negedge clk);
      check("R8 step after restart", 15'h0103, 2'd1);

      // R1: reset in the middle of a burst
      rst_n = 1'b0;
      #1 check("R1 mid-burst reset", '0, '0);
      @(negedge clk);
      check("R1 held in reset", '0, '0);

      done = 1'b1;
      finish_run();
   end

endmodule